// File: doc/BRIEF.md
# Double-Buffered Byte Transmit Path

This block is the sending half of a byte-serial controller. Software places a byte in a one-byte holding buffer through a write strobe. As soon as the shift register behind it is free, the byte moves across. The shift register then presents its bits, most significant first, to a line engine, which advances it with a shift strobe. Because the buffer and the shifter are separate stages, software can queue the next byte while the current one is still going out, and back-to-back bytes leave with no gap.

Software follows progress through three status levels and three sticky interrupt flags. A room indication says the holding buffer can take a byte. A transmit-complete indication says the shifter ran dry with nothing queued. An overflow flag reports a write that found the buffer occupied. A flush command discards queued data. A byte that has already started on the line is always allowed to finish.

Top module: `tx_dbuf_path`

## Requirements
- R1: The shifter drives `ser_bit` with its most significant bit first and advances one bit per cycle in which `shift_stb` is high. `ser_bit` is 0 and `shift_stb` has no effect while `ser_active` is low.
- R2: A byte in the holding buffer is loaded into the shifter on the clock edge where the shifter is empty, or where it receives its eighth strobe. From that edge, `ser_active` is high and `ser_bit` shows the new byte's MSB. A byte written into an empty buffer reaches the shifter one cycle after the write at the earliest.
- R3: When the eighth strobe completes a byte and the holding buffer is empty (or is being flushed) and no write is accepted in that cycle, `st_tx_done` and `irq_tx_done` are both set on that edge.
- R4: `st_tx_done` clears on the edge of an accepted write. `irq_tx_done` stays set until `irq_done_clr` is pulsed.
- R5: Every transfer from the holding buffer to the shifter sets `st_buf_room` and `irq_buf_room`.
- R6: A write accepted into an empty holding buffer clears `st_buf_room` on that edge.
- R7: A write while the holding buffer is occupied sets `irq_overflow`. The queued byte is kept and is the next one shifted out. The new byte is dropped.
- R8: `flush` empties the holding buffer and sets `st_buf_room`. It also discards a shifter byte that has not yet received any strobe, including on a cycle where a strobe arrives. A byte with at least one bit sent completes normally. A write in a flush cycle is ignored and raises no overflow.
- R9: After reset, `st_buf_room` is 1 and every other output is 0.
- R10: Each interrupt flag holds until its clear input is high. If a setting event and the clear fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to queue |
| flush | input | 1 | Discard queued data |
| shift_stb | input | 1 | Line engine requests the next bit |
| irq_room_clr | input | 1 | Clears `irq_buf_room` |
| irq_done_clr | input | 1 | Clears `irq_tx_done` |
| irq_ovf_clr | input | 1 | Clears `irq_overflow` |
| ser_bit | output | 1 | Current bit for the line |
| ser_active | output | 1 | Shifter holds a byte |
| st_buf_room | output | 1 | Holding buffer is empty |
| st_tx_done | output | 1 | Shifter ran out of data |
| irq_buf_room | output | 1 | Sticky: a byte moved to the shifter |
| irq_tx_done | output | 1 | Sticky: transmission ran dry |
| irq_overflow | output | 1 | Sticky: write found buffer full |

## Verification
Any fault in the buffer occupancy, the shifter byte or its bit counter becomes visible at the ports within at most one byte time. A lost or duplicated byte changes the `ser_bit` pattern or `ser_active` on the very next strobe or load edge. A bit counter that is off by one moves the edge where `ser_active` drops or where the next MSB appears. A wrong occupancy bit shows at once in `st_buf_room`, and on the next write it also shows in `irq_overflow`. Because of this, a model that compares every output on every cycle catches a divergence within a few cycles of its cause, under directed sequences around flushes and overflows and under long random traffic.

// File: rtl/tx_dbuf_pkg.sv
package tx_dbuf_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } hold_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
    } shift_t;

    typedef struct packed {
        logic st_room;
        logic st_done;
        logic irq_room;
        logic irq_done;
        logic irq_ovf;
    } flags_t;

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf
    import tx_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flush,
    input  logic              take,
    output logic              valid,
    output logic [BYTE_W-1:0] data,
    output logic              accept,
    output logic              overflow
);
    hold_t hold_d, hold_q;

    always_comb begin
        accept   = wr_en && !flush && !hold_q.valid;
        overflow = wr_en && !flush && hold_q.valid;
        hold_d   = hold_q;
        if (flush || take) begin
            hold_d.valid = 1'b0;
        end
        if (accept) begin
            hold_d.valid = 1'b1;
            hold_d.data  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign valid = hold_q.valid;
    assign data  = hold_q.data;
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import tx_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              flush,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic              ready,
    output logic              done,
    output logic              ser_bit,
    output logic              active
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    shift_t sh_d, sh_q;

    always_comb begin
        done  = sh_q.valid && stb && (sh_q.cnt == LAST);
        ready = !sh_q.valid || done;
        sh_d  = sh_q;
        if (flush && sh_q.valid && (sh_q.cnt == '0)) begin
            sh_d.valid = 1'b0;
        end else if (sh_q.valid && stb) begin
            sh_d.data = {sh_q.data[BYTE_W-2:0], 1'b0};
            sh_d.cnt  = sh_q.cnt + 1'b1;
            if (done) begin
                sh_d.valid = 1'b0;
                sh_d.cnt   = '0;
            end
        end
        if (load) begin
            sh_d.valid = 1'b1;
            sh_d.data  = load_data;
            sh_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign ser_bit = sh_q.valid && sh_q.data[BYTE_W-1];
    assign active  = sh_q.valid;
endmodule

// File: rtl/tx_flag_unit.sv
module tx_flag_unit
    import tx_dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic take,
    input  logic flush,
    input  logic done,
    input  logic buf_empty_now,
    input  logic overflow,
    input  logic room_clr,
    input  logic done_clr,
    input  logic ovf_clr,
    output flags_t flags
);
    flags_t fl_d, fl_q;
    logic   set_done;

    always_comb begin
        set_done = done && buf_empty_now && !accept;
        fl_d     = fl_q;

        if (take || flush)      fl_d.st_room = 1'b1;
        else if (accept)        fl_d.st_room = 1'b0;

        if (set_done)           fl_d.st_done = 1'b1;
        else if (accept)        fl_d.st_done = 1'b0;

        if (take)               fl_d.irq_room = 1'b1;
        else if (room_clr)      fl_d.irq_room = 1'b0;

        if (set_done)           fl_d.irq_done = 1'b1;
        else if (done_clr)      fl_d.irq_done = 1'b0;

        if (overflow)           fl_d.irq_ovf = 1'b1;
        else if (ovf_clr)       fl_d.irq_ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '{st_room: 1'b1, default: 1'b0};
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;
endmodule

// File: rtl/tx_dbuf_path.sv
module tx_dbuf_path
    import tx_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flush,
    input  logic              shift_stb,
    input  logic              irq_room_clr,
    input  logic              irq_done_clr,
    input  logic              irq_ovf_clr,
    output logic              ser_bit,
    output logic              ser_active,
    output logic              st_buf_room,
    output logic              st_tx_done,
    output logic              irq_buf_room,
    output logic              irq_tx_done,
    output logic              irq_overflow
);
    logic              hb_valid, hb_accept, hb_ovf;
    logic [BYTE_W-1:0] hb_data;
    logic              sh_ready, sh_done, take;
    flags_t            flags;

    assign take = hb_valid && sh_ready && !flush;

    tx_hold_buf u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .flush    (flush),
        .take     (take),
        .valid    (hb_valid),
        .data     (hb_data),
        .accept   (hb_accept),
        .overflow (hb_ovf)
    );

    tx_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (shift_stb),
        .flush     (flush),
        .load      (take),
        .load_data (hb_data),
        .ready     (sh_ready),
        .done      (sh_done),
        .ser_bit   (ser_bit),
        .active    (ser_active)
    );

    tx_flag_unit u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept        (hb_accept),
        .take          (take),
        .flush         (flush),
        .done          (sh_done),
        .buf_empty_now (!hb_valid || flush),
        .overflow      (hb_ovf),
        .room_clr      (irq_room_clr),
        .done_clr      (irq_done_clr),
        .ovf_clr       (irq_ovf_clr),
        .flags         (flags)
    );

    assign st_buf_room  = flags.st_room;
    assign st_tx_done   = flags.st_done;
    assign irq_buf_room = flags.irq_room;
    assign irq_tx_done  = flags.irq_done;
    assign irq_overflow = flags.irq_ovf;
endmodule

// File: rtl/tx_dbuf_path_chk.sv
module tx_dbuf_path_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic flush,
    input logic shift_stb,
    input logic irq_done_clr,
    input logic irq_ovf_clr,
    input logic ser_bit,
    input logic ser_active,
    input logic st_buf_room,
    input logic st_tx_done,
    input logic irq_tx_done,
    input logic irq_overflow
);
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_active |-> !ser_bit);

    a_r2_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ser_active && !shift_stb && !flush |=> ser_active && $stable(ser_bit));

    a_r3_done_after_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_tx_done) |-> $past(ser_active));

    a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_done && !irq_done_clr |=> irq_tx_done);

    a_r4_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        st_tx_done && wr_en && !flush |=> !st_tx_done);

    a_r6_room_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !flush && st_buf_room |=> !st_buf_room);

    a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !flush && !st_buf_room |=> irq_overflow);

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq_overflow && !irq_ovf_clr |=> irq_overflow);
endmodule

bind tx_dbuf_path tx_dbuf_path_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .flush        (flush),
    .shift_stb    (shift_stb),
    .irq_done_clr (irq_done_clr),
    .irq_ovf_clr  (irq_ovf_clr),
    .ser_bit      (ser_bit),
    .ser_active   (ser_active),
    .st_buf_room  (st_buf_room),
    .st_tx_done   (st_tx_done),
    .irq_tx_done  (irq_tx_done),
    .irq_overflow (irq_overflow)
);

// File: tb/tx_dbuf_path_test.sv
module tx_dbuf_path_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       flush = 1'b0;
    logic       shift_stb = 1'b0;
    logic       irq_room_clr = 1'b0;
    logic       irq_done_clr = 1'b0;
    logic       irq_ovf_clr = 1'b0;
    logic       ser_bit, ser_active, st_buf_room, st_tx_done;
    logic       irq_buf_room, irq_tx_done, irq_overflow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural reference state
    logic [7:0] m_queue[$];
    bit         m_busy;
    logic [7:0] m_byte;
    int         m_sent;
    bit m_room, m_done, m_irq_room, m_irq_done, m_irq_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_dbuf_path uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flush(flush), .shift_stb(shift_stb), .irq_room_clr(irq_room_clr),
        .irq_done_clr(irq_done_clr), .irq_ovf_clr(irq_ovf_clr),
        .ser_bit(ser_bit), .ser_active(ser_active), .st_buf_room(st_buf_room),
        .st_tx_done(st_tx_done), .irq_buf_room(irq_buf_room),
        .irq_tx_done(irq_tx_done), .irq_overflow(irq_overflow)
    );

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_queue.delete();
        m_busy = 0; m_byte = 0; m_sent = 0;
        m_room = 1; m_done = 0; m_irq_room = 0; m_irq_done = 0; m_irq_ovf = 0;
    endtask

    task automatic model_step();
        bit fin, acc, ovf, moved, empty_now;
        fin       = m_busy && shift_stb && (m_sent == 7);
        acc       = wr_en && !flush && (m_queue.size() == 0);
        ovf       = wr_en && !flush && (m_queue.size() != 0);
        empty_now = (m_queue.size() == 0) || flush;
        moved     = (m_queue.size() != 0) && !flush && (!m_busy || fin);
        if (flush && m_busy && m_sent == 0) begin
            m_busy = 0;
        end else if (m_busy && shift_stb) begin
            m_sent++;
            if (m_sent == 8) begin m_busy = 0; m_sent = 0; end
        end
        if (moved) begin
            m_byte = m_queue.pop_front();
            m_busy = 1; m_sent = 0;
        end
        if (flush) m_queue.delete();
        if (acc) m_queue.push_back(wr_data);
        if (moved || flush) m_room = 1; else if (acc) m_room = 0;
        if (fin && empty_now && !acc) begin m_done = 1; m_irq_done = 1; end
        else begin
            if (acc) m_done = 0;
            if (irq_done_clr) m_irq_done = 0;
        end
        if (moved) m_irq_room = 1; else if (irq_room_clr) m_irq_room = 0;
        if (ovf) m_irq_ovf = 1; else if (irq_ovf_clr) m_irq_ovf = 0;
    endtask

    task automatic compare();
        logic exp_bit;
        exp_bit = m_busy ? m_byte[7 - m_sent] : 1'b0;
        chk("R1", "ser_bit", 8'(ser_bit), 8'(exp_bit));
        chk("R2", "ser_active", 8'(ser_active), 8'(m_busy));
        chk("R5", "st_buf_room", 8'(st_buf_room), 8'(m_room));
        chk("R3", "st_tx_done", 8'(st_tx_done), 8'(m_done));
        chk("R10", "irq_buf_room", 8'(irq_buf_room), 8'(m_irq_room));
        chk("R4", "irq_tx_done", 8'(irq_tx_done), 8'(m_irq_done));
        chk("R7", "irq_overflow", 8'(irq_overflow), 8'(m_irq_ovf));
    endtask

    task automatic cyc(bit w, logic [7:0] wd, bit f, bit s, bit rc, bit dc, bit oc);
        @(negedge clk);
        wr_en = w; wr_data = wd; flush = f; shift_stb = s;
        irq_room_clr = rc; irq_done_clr = dc; irq_ovf_clr = oc;
        @(posedge clk);
        #1;
        model_step();
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 0, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R9: reset values
        chk("R9", "st_buf_room", 8'(st_buf_room), 8'h1);
        chk("R9", "st_tx_done", 8'(st_tx_done), 8'h0);
        chk("R9", "ser_active", 8'(ser_active), 8'h0);
        chk("R9", "irq flags", {5'b0, irq_buf_room, irq_tx_done, irq_overflow}, 8'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: MSB first, strobes while idle do nothing
        cyc(0, 8'h00, 0, 1, 0, 0, 0);
        cyc(1, 8'hA5, 0, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 0, 0, 0);
        got = 8'h00;
        for (int i = 0; i < 8; i++) begin
            got = {got[6:0], ser_bit};
            cyc(0, 8'h00, 0, 1, 0, 0, 0);
        end
        chk("R1", "serial byte", got, 8'hA5);
        chk("R3", "st_tx_done after byte", 8'(st_tx_done), 8'h1);

        // R4: write clears status, irq stays until cleared
        cyc(1, 8'h3C, 0, 0, 0, 0, 0);
        chk("R4", "st_tx_done after write", 8'(st_tx_done), 8'h0);
        chk("R4", "irq_tx_done held", 8'(irq_tx_done), 8'h1);
        cyc(0, 8'h00, 0, 0, 0, 1, 0);
        chk("R4", "irq_tx_done cleared", 8'(irq_tx_done), 8'h0);

        // R7: overflow keeps the queued byte
        cyc(1, 8'h81, 0, 0, 0, 0, 0);
        cyc(1, 8'hFF, 0, 0, 0, 0, 0);
        chk("R7", "irq_overflow", 8'(irq_overflow), 8'h1);
        for (int i = 0; i < 8; i++) cyc(0, 8'h00, 0, 1, 0, 0, 0);
        got = 8'h00;
        for (int i = 0; i < 8; i++) begin
            got = {got[6:0], ser_bit};
            cyc(0, 8'h00, 0, 1, 0, 0, 0);
        end
        chk("R7", "kept byte", got, 8'h81);
        cyc(0, 8'h00, 0, 0, 1, 1, 1);

        // R8: flush mid-byte completes in-flight byte, drops queued
        cyc(1, 8'hF0, 0, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 1, 0, 0, 0);
        cyc(1, 8'h0F, 0, 1, 0, 0, 0);
        cyc(1, 8'h55, 1, 1, 0, 0, 0);
        chk("R8", "room after flush", 8'(st_buf_room), 8'h1);
        chk("R8", "no overflow on flush write", 8'(irq_overflow), 8'h0);
        for (int i = 0; i < 6; i++) cyc(0, 8'h00, 0, 1, 0, 0, 0);
        chk("R8", "in-flight byte finished", 8'(ser_active), 8'h0);

        // R8: flush drops a fresh byte even with a strobe
        cyc(1, 8'h77, 0, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 0, 0, 0);
        cyc(0, 8'h00, 1, 1, 0, 0, 0);
        chk("R8", "fresh byte dropped", 8'(ser_active), 8'h0);

        // R10: set wins over clear
        cyc(1, 8'h11, 0, 0, 0, 0, 0);
        cyc(1, 8'h22, 0, 0, 1, 0, 1);
        chk("R10", "ovf set beats clear", 8'(irq_overflow), 8'h1);
        idle(2);

        // R2, R5, R6: random traffic with back-to-back loads
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 3) == 0, 8'($urandom), ($urandom % 50) == 0,
                ($urandom % 2) == 0, ($urandom % 8) == 0,
                ($urandom % 8) == 0, ($urandom % 8) == 0);
        end
        idle(4);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule